// File: doc/BRIEF.md
# One-Bit LRU TLB Victim Selector

This block owns a 64-slot translation buffer (a tag word and a translation-entry word per slot). It chooses where a new tag/entry pair goes when one is inserted automatically. An insert is a staged search. The first stage looks for any slot that is not valid. If every slot is valid, it looks for a slot that is neither pinned (locked) nor recently referenced (used). If that also fails, the used flags of all slots are cleared in a single cycle and the unlocked search is run once more. The insert fails only when every slot is pinned.

The block also takes direct indexed writes, where the slot number comes from bits 8:3 of a byte address and no search is made. A lookup path outside the block reports hits through a touch port, which sets the used flag of the slot that was hit. A combinational read port exposes any slot's contents. The block reports the chosen slot, a one-cycle done pulse per insert and a failure flag.

Top module: `tlbv_lru_victim`

## Requirements
- R1: An insert writes the lowest-numbered slot whose valid flag (entry bit 63) is 0, even when unlocked unused slots also exist.
- R2: If every slot is valid, an insert writes the lowest-numbered slot whose lock flag (entry bit 6) and used flag (entry bit 41) are both 0.
- R3: If every slot is valid and none is both unlocked and unused, one cycle clears bit 41 in all slots. The unlocked-unused search then runs once more, and its winner is written.
- R4: If the retry also finds no slot, done and fail are raised together and no slot's tag or entry is written. The used flags stay cleared, and victim_idx reads 0.
- R5: A direct write in the idle state writes new_tag/new_tte into slot dir_addr[8:3] at the sampling edge, ignores all other address bits and raises no done pulse.
- R6: Each accepted insert gives exactly one done pulse, two clock edges after the strobe edge for a first-pass result, or three edges when the retry is needed. victim_idx holds the written slot from that pulse on.
- R7: touch_req sets bit 41 of slot touch_idx at the next edge. If a write lands on the same slot in that cycle, the written entry wins.
- R8: While busy, ins_req and dir_req are ignored. In idle, an ins_req in the same cycle as a dir_req wins and the direct write is dropped.
- R9: After reset, every slot's tag and entry read 0 (all invalid), busy, done and fail are low, and victim_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_req | input | 1 | Start an automatic insert of new_tag/new_tte |
| dir_req | input | 1 | Direct indexed write of new_tag/new_tte |
| dir_addr | input | 64 | Byte address for direct writes; bits 8:3 select the slot |
| new_tag | input | 64 | Tag to be written |
| new_tte | input | 64 | Translation entry to be written |
| touch_req | input | 1 | Lookup hit: mark slot touch_idx as used |
| touch_idx | input | 6 | Slot that was hit |
| rd_idx | input | 6 | Slot to show on the read port |
| busy | output | 1 | Insert search in progress |
| done | output | 1 | One-cycle pulse at the end of an insert |
| fail | output | 1 | With done: every slot was pinned |
| victim_idx | output | 6 | Slot written by the last insert |
| rd_tag | output | 64 | Tag of slot rd_idx |
| rd_tte | output | 64 | Entry of slot rd_idx |

## Verification
The hardest state to reach is the retry path. It needs a table that is entirely valid, where every unpinned slot has its used flag set and at least one slot is unpinned. The stimulus fills the table through inserts, then touches every slot before the next insert. A separate run rewrites every slot as pinned through direct writes to reach the failure case. Busy-time strobes are placed on the exact cycle after acceptance, and a touch is aimed at the very slot a direct write lands on in the same cycle.

// File: rtl/tlbv_pkg.sv
// Package: shared types for the TLB victim selector.
// Assumes: one insert at a time; the state encoding is internal only.
package tlbv_pkg;

    // Search stages of an automatic insert
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_RETRY = 2'd2
    } srch_state_t;

    // Entries are 8 bytes apart in the direct-access address space
    localparam int IDX_LSB = 3;

endpackage

// File: rtl/tlbv_prio_enc.sv
// Module: lowest-index priority encoder.
// Finds the lowest set bit of req. found is low and idx is 0 when req is empty.
// Assumes: N is a power of two with IDX_W = log2(N).
module tlbv_prio_enc #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest request is the last to be assigned
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Any request present
    assign found = |req;

endmodule

// File: rtl/tlbv_entry_array.sv
// Module: slot storage for the TLB victim selector.
// Holds a tag and an entry word per slot. It has one write port, a
// clear-all-used strobe, a touch port that sets one used flag, and a
// combinational read port. Priority per slot: write > touch > clear.
// Assumes: the controller never writes and clears in the same cycle.
module tlbv_entry_array #(
    parameter int ENTRIES   = 64,
    parameter int TAG_W     = 64,
    parameter int TTE_W     = 64,
    parameter int VALID_BIT = 63,
    parameter int USED_BIT  = 41,
    parameter int LOCK_BIT  = 6,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [TTE_W-1:0]   wr_tte,
    input  logic               clr_used,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [TTE_W-1:0]   rd_tte,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] used_vec,
    output logic [ENTRIES-1:0] lock_vec
);

    logic [TAG_W-1:0] tag_q [ENTRIES];
    logic [TTE_W-1:0] tte_q [ENTRIES];

    // Slot update: reset to invalid, full write, or used-flag maintenance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                tte_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    tag_q[i] <= wr_tag;
                    tte_q[i] <= wr_tte;
                end else begin
                    if (clr_used) tte_q[i][USED_BIT] <= 1'b0;
                    if (touch_en && (touch_idx == IDX_W'(i))) tte_q[i][USED_BIT] <= 1'b1;
                end
            end
        end
    end

    // Per-slot flag vectors for the search logic
    for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
        assign valid_vec[g] = tte_q[g][VALID_BIT];
        assign used_vec[g]  = tte_q[g][USED_BIT];
        assign lock_vec[g]  = tte_q[g][LOCK_BIT];
    end

    // Read port
    assign rd_tag = tag_q[rd_idx];
    assign rd_tte = tte_q[rd_idx];

    // A written entry is present at the next edge
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tte_q[$past(wr_idx)] == $past(wr_tte))); // R5

    // A clear without a touch leaves no used flag set
    AST_USED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_used && !touch_en && !wr_en) |=> (used_vec == '0)); // R3

endmodule

// File: rtl/tlbv_ctrl.sv
// Module: staged-search controller for the TLB victim selector.
// Idle: accepts an insert (priority) or performs a direct write.
// First stage: writes an invalid slot or an unlocked unused slot; otherwise
// clears all used flags. Retry stage: writes an unlocked unused slot or
// reports failure. Done, fail and the victim index are registered.
// Assumes: search inputs come from the current array contents.
module tlbv_ctrl
    import tlbv_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_req,
    input  logic             dir_req,
    input  logic [IDX_W-1:0] dir_idx,
    input  logic             any_inv,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             any_uu,
    input  logic [IDX_W-1:0] uu_idx,
    output logic             accept,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_from_pend,
    output logic             clr_used,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [IDX_W-1:0] victim_idx
);

    srch_state_t state_q, state_d;
    logic        fin;
    logic        fin_fail;

    // Next-state, write-port and finish decode per search stage
    always_comb begin
        state_d      = state_q;
        accept       = 1'b0;
        wr_en        = 1'b0;
        wr_idx       = '0;
        wr_from_pend = 1'b0;
        clr_used     = 1'b0;
        fin          = 1'b0;
        fin_fail     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (ins_req) begin
                    accept  = 1'b1;
                    state_d = ST_FIRST;
                end else if (dir_req) begin
                    wr_en  = 1'b1;
                    wr_idx = dir_idx;
                end
            end
            ST_FIRST: begin
                if (any_inv) begin
                    wr_en        = 1'b1;
                    wr_idx       = inv_idx;
                    wr_from_pend = 1'b1;
                    fin          = 1'b1;
                    state_d      = ST_IDLE;
                end else if (any_uu) begin
                    wr_en        = 1'b1;
                    wr_idx       = uu_idx;
                    wr_from_pend = 1'b1;
                    fin          = 1'b1;
                    state_d      = ST_IDLE;
                end else begin
                    clr_used = 1'b1;
                    state_d  = ST_RETRY;
                end
            end
            ST_RETRY: begin
                fin     = 1'b1;
                state_d = ST_IDLE;
                if (any_uu) begin
                    wr_en        = 1'b1;
                    wr_idx       = uu_idx;
                    wr_from_pend = 1'b1;
                end else begin
                    fin_fail = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Search state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered completion outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            fail       <= 1'b0;
            victim_idx <= '0;
        end else begin
            done <= fin;
            fail <= fin_fail;
            if (fin) victim_idx <= fin_fail ? '0 : wr_idx;
        end
    end

    assign busy = (state_q != ST_IDLE);

    // Consecutive busy cycles, for the latency bound check
    logic [1:0] busy_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_run <= '0;
        else if (!busy)            busy_run <= '0;
        else if (busy_run != 2'd3) busy_run <= busy_run + 2'd1;
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run <= 2'd1)); // R6

    AST_DONE_AFTER_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state_q != ST_IDLE)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && $past(state_q == ST_RETRY))); // R4

endmodule

// File: rtl/tlbv_lru_victim.sv
// Module: one-bit LRU TLB victim selector (top).
// Owns the slot array, two lowest-index searches (invalid slots and
// unlocked-unused slots) and the staged controller. It latches the insert
// data on acceptance and muxes direct-write data from the ports.
// Assumes: touch_req comes from an external lookup path.
module tlbv_lru_victim
    import tlbv_pkg::*;
#(
    parameter int ENTRIES   = 64,
    parameter int TAG_W     = 64,
    parameter int TTE_W     = 64,
    parameter int ADDR_W    = 64,
    parameter int VALID_BIT = 63,
    parameter int USED_BIT  = 41,
    parameter int LOCK_BIT  = 6,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_req,
    input  logic             dir_req,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic [TAG_W-1:0] new_tag,
    input  logic [TTE_W-1:0] new_tte,
    input  logic             touch_req,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [IDX_W-1:0] victim_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TTE_W-1:0] rd_tte
);

    logic [ENTRIES-1:0] valid_vec, used_vec, lock_vec;
    logic               any_inv, any_uu;
    logic [IDX_W-1:0]   inv_idx, uu_idx;
    logic               accept, wr_en, wr_from_pend, clr_used;
    logic [IDX_W-1:0]   wr_idx, dir_idx;
    logic [TAG_W-1:0]   pend_tag, wr_tag;
    logic [TTE_W-1:0]   pend_tte, wr_tte;
    logic               addr_unused;

    // Slot number from the byte address; other address bits do not matter
    assign dir_idx     = dir_addr[IDX_LSB +: IDX_W];
    assign addr_unused = ^{dir_addr[ADDR_W-1:IDX_LSB+IDX_W], dir_addr[IDX_LSB-1:0]};

    // Hold the insert data for the length of the search
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tag <= '0;
            pend_tte <= '0;
        end else if (accept) begin
            pend_tag <= new_tag;
            pend_tte <= new_tte;
        end
    end

    // Write data: held insert data or direct-write data
    assign wr_tag = wr_from_pend ? pend_tag : new_tag;
    assign wr_tte = wr_from_pend ? pend_tte : new_tte;

    tlbv_entry_array #(
        .ENTRIES  (ENTRIES),
        .TAG_W    (TAG_W),
        .TTE_W    (TTE_W),
        .VALID_BIT(VALID_BIT),
        .USED_BIT (USED_BIT),
        .LOCK_BIT (LOCK_BIT)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_tte   (wr_tte),
        .clr_used (clr_used),
        .touch_en (touch_req),
        .touch_idx(touch_idx),
        .rd_idx   (rd_idx),
        .rd_tag   (rd_tag),
        .rd_tte   (rd_tte),
        .valid_vec(valid_vec),
        .used_vec (used_vec),
        .lock_vec (lock_vec)
    );

    tlbv_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_find_inv (
        .req  (~valid_vec),
        .found(any_inv),
        .idx  (inv_idx)
    );

    tlbv_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_find_uu (
        .req  (~lock_vec & ~used_vec),
        .found(any_uu),
        .idx  (uu_idx)
    );

    tlbv_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_req     (ins_req),
        .dir_req     (dir_req),
        .dir_idx     (dir_idx),
        .any_inv     (any_inv),
        .inv_idx     (inv_idx),
        .any_uu      (any_uu),
        .uu_idx      (uu_idx),
        .accept      (accept),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_from_pend(wr_from_pend),
        .clr_used    (clr_used),
        .busy        (busy),
        .done        (done),
        .fail        (fail),
        .victim_idx  (victim_idx)
    );

    // A successful insert lands on a slot that was free or unpinned
    AST_VICTIM_UNPINNED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_from_pend) |-> (!valid_vec[wr_idx] || !lock_vec[wr_idx])); // R2

    // Invalid slots are always preferred on the first stage
    AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_from_pend && any_inv) |-> !valid_vec[wr_idx]); // R1

endmodule

// File: tb/tb_tlbv_lru_victim.sv
`timescale 1ns/1ps
module tb_tlbv_lru_victim;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_req = 1'b0, dir_req = 1'b0, touch_req = 1'b0;
    logic [63:0] dir_addr = '0, new_tag = '0, new_tte = '0;
    logic [5:0]  touch_idx = '0, rd_idx = '0;
    logic        busy, done, fail;
    logic [5:0]  victim_idx;
    logic [63:0] rd_tag, rd_tte;

    int vectors = 0;
    int miscmp  = 0;
    int cyc     = 0;
    bit chk_en  = 0;
    bit scan_en = 0;

    always #2.5 clk = ~clk;

    tlbv_lru_victim dut (
        .clk(clk), .rst_n(rst_n), .ins_req(ins_req), .dir_req(dir_req),
        .dir_addr(dir_addr), .new_tag(new_tag), .new_tte(new_tte),
        .touch_req(touch_req), .touch_idx(touch_idx), .rd_idx(rd_idx),
        .busy(busy), .done(done), .fail(fail), .victim_idx(victim_idx),
        .rd_tag(rd_tag), .rd_tte(rd_tte)
    );

    // ---------------- behavioural reference model ----------------
    bit [63:0] m_tag [64];
    bit [63:0] m_tte [64];
    int        m_state;
    bit [63:0] p_tag, p_tte;
    bit        e_done, e_fail;
    int        e_vic;

    function automatic int find_invalid();
        for (int i = 0; i < 64; i++) if (!m_tte[i][63]) return i;
        return -1;
    endfunction

    function automatic int find_free();
        for (int i = 0; i < 64; i++) if (!m_tte[i][6] && !m_tte[i][41]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        int wi, pick;
        bit clr, d, f;
        bit [63:0] wt, wv;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
            m_state = 0; e_done = 0; e_fail = 0; e_vic = 0; p_tag = '0; p_tte = '0;
        end else begin
            wi = -1; clr = 0; d = 0; f = 0; wt = '0; wv = '0;
            if (m_state == 0) begin
                if (ins_req) begin p_tag = new_tag; p_tte = new_tte; m_state = 1; end
                else if (dir_req) begin wi = int'((dir_addr >> 3) & 64'd63); wt = new_tag; wv = new_tte; end
            end else if (m_state == 1) begin
                pick = find_invalid();
                if (pick < 0) pick = find_free();
                if (pick >= 0) begin wi = pick; wt = p_tag; wv = p_tte; d = 1; m_state = 0; end
                else begin clr = 1; m_state = 2; end
            end else begin
                pick = find_free();
                d = 1; m_state = 0;
                if (pick >= 0) begin wi = pick; wt = p_tag; wv = p_tte; end
                else f = 1;
            end
            if (clr) for (int i = 0; i < 64; i++) m_tte[i][41] = 1'b0;
            if (touch_req) m_tte[touch_idx][41] = 1'b1;
            if (wi >= 0) begin m_tag[wi] = wt; m_tte[wi] = wv; end
            e_done = d; e_fail = f;
            if (d) e_vic = f ? 0 : wi;
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model, plus a rolling scan of the array
    always @(negedge clk) begin
        if (chk_en) begin
            chk("R8", "busy", 64'(busy), 64'(m_state != 0));
            chk("R6", "done", 64'(done), 64'(e_done));
            chk("R4", "fail", 64'(fail), 64'(e_fail));
            chk("R2", "victim_idx", 64'(victim_idx), 64'(e_vic));
            if (scan_en) begin
                chk("R5", "scan tag", rd_tag, m_tag[rd_idx]);
                chk("R5", "scan tte", rd_tte, m_tte[rd_idx]);
                rd_idx = rd_idx + 6'd1;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            miscmp++;
            $display("FAIL R6 watchdog: actual %0d cycles expected below 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [63:0] mk(bit v, bit l, bit u, int p);
        logic [63:0] t = '0;
        t[63] = v; t[41] = u; t[6] = l; t[23:8] = 16'(p);
        return t;
    endfunction

    task automatic do_insert(logic [63:0] tg, logic [63:0] tt, output int vic, output bit f, output int lat);
        ins_req = 1; new_tag = tg; new_tte = tt;
        @(negedge clk); ins_req = 0; lat = 1;
        while (!done && lat < 6) begin @(negedge clk); lat++; end
        vic = int'(victim_idx); f = fail;
    endtask

    task automatic do_dir(int idx, logic [63:0] extra, logic [63:0] tg, logic [63:0] tt);
        dir_req = 1; dir_addr = extra | (64'(idx) << 3); new_tag = tg; new_tte = tt;
        @(negedge clk); dir_req = 0;
    endtask

    task automatic do_touch(int idx);
        touch_req = 1; touch_idx = 6'(idx);
        @(negedge clk); touch_req = 0;
    endtask

    task automatic peek(string req, int idx, logic [63:0] etag, logic [63:0] ette);
        scan_en = 0;
        #1 rd_idx = 6'(idx);
        #1;
        chk(req, $sformatf("slot %0d tag", idx), rd_tag, etag);
        chk(req, $sformatf("slot %0d tte", idx), rd_tte, ette);
        @(negedge clk); scan_en = 1;
    endtask

    int  vic, lat, dones;
    bit  f;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; chk_en = 1;
        // R9: reset state
        chk("R9", "busy after reset", 64'(busy), 64'd0);
        chk("R9", "victim after reset", 64'(victim_idx), 64'd0);
        peek("R9", 5, 64'd0, 64'd0);

        // R1: fill from empty, lowest invalid slot each time, first-pass latency
        for (int k = 0; k < 64; k++) begin
            do_insert(64'hA000 + 64'(k), mk(1, k < 3, 0, k), vic, f, lat);
            chk("R1", "fill victim", 64'(vic), 64'(k));
            if (k == 0 || k == 63) chk("R6", "first-pass latency", 64'(lat), 64'd2);
        end

        // R2 and R7: slots 3,4 used, 0..2 locked -> slot 5
        do_touch(3); do_touch(4);
        peek("R7", 3, 64'hA003, mk(1, 0, 1, 3));
        do_insert(64'hB005, mk(1, 0, 0, 16'hB5), vic, f, lat);
        chk("R2", "unlocked unused victim", 64'(vic), 64'd5);
        chk("R2", "no fail", 64'(f), 64'd0);

        // R5: direct write, high and low address bits ignored, no done pulse
        do_dir(10, 64'hF000_0000_0000_0005, 64'hD010, mk(1, 0, 0, 16'hA10));
        chk("R5", "no done on direct write", 64'(done), 64'd0);
        peek("R5", 10, 64'hD010, mk(1, 0, 0, 16'hA10));

        // R1: invalid slot 20 preferred over unlocked unused slot 6
        do_dir(20, 64'd0, 64'd0, 64'd0);
        do_insert(64'hC020, mk(1, 0, 0, 20), vic, f, lat);
        chk("R1", "invalid preferred", 64'(vic), 64'd20);

        // R3: every slot used -> clear, retry, lowest unlocked
        for (int k = 0; k < 64; k++) do_touch(k);
        do_insert(64'hE003, mk(1, 0, 0, 16'hE3), vic, f, lat);
        chk("R3", "retry victim", 64'(vic), 64'd3);
        chk("R6", "retry latency", 64'(lat), 64'd3);
        peek("R3", 4, 64'hA004, mk(1, 0, 0, 4));
        peek("R3", 0, 64'hA000, mk(1, 1, 0, 0));

        // R4: every slot locked -> fail, nothing written, used flags cleared
        for (int k = 0; k < 64; k++) do_dir(k, 64'd0, 64'hC0DE_0000 + 64'(k), mk(1, 1, 0, k));
        do_touch(7); do_touch(50);
        do_insert(64'hBAD, mk(1, 0, 0, 16'hBAD), vic, f, lat);
        chk("R4", "fail flag", 64'(f), 64'd1);
        chk("R4", "victim on fail", 64'(vic), 64'd0);
        chk("R6", "fail latency", 64'(lat), 64'd3);
        peek("R4", 7, 64'hC0DE_0007, mk(1, 1, 0, 7));
        peek("R4", 0, 64'hC0DE_0000, mk(1, 1, 0, 0));

        // R8: strobes while busy are ignored
        do_dir(40, 64'd0, 64'd0, 64'd0);
        ins_req = 1; new_tag = 64'hAAAA; new_tte = mk(1, 1, 0, 16'hAA);
        @(negedge clk);
        chk("R8", "busy after accept", 64'(busy), 64'd1);
        new_tag = 64'hBBBB; new_tte = mk(1, 1, 0, 16'hBB);
        dir_req = 1; dir_addr = 64'(50) << 3;
        @(negedge clk);
        ins_req = 0; dir_req = 0;
        chk("R8", "done for first insert", 64'(done), 64'd1);
        chk("R8", "victim for first insert", 64'(victim_idx), 64'd40);
        dones = 0;
        repeat (4) begin @(negedge clk); if (done) dones++; end
        chk("R8", "no second done", 64'(dones), 64'd0);
        peek("R8", 40, 64'hAAAA, mk(1, 1, 0, 16'hAA));
        peek("R8", 50, 64'hC0DE_0032, mk(1, 1, 0, 50));

        // R8: insert beats a simultaneous direct write in idle
        do_dir(41, 64'd0, 64'd0, 64'd0);
        ins_req = 1; dir_req = 1; dir_addr = 64'(60) << 3;
        new_tag = 64'h4141; new_tte = mk(1, 1, 0, 16'h41);
        @(negedge clk); ins_req = 0; dir_req = 0;
        @(negedge clk);
        chk("R8", "insert wins victim", 64'(victim_idx), 64'd41);
        peek("R8", 60, 64'hC0DE_003C, mk(1, 1, 0, 60));

        // R7: write to the touched slot wins
        touch_req = 1; touch_idx = 6'd30;
        do_dir(30, 64'd0, 64'h3030, mk(1, 0, 0, 16'h30));
        touch_req = 0;
        peek("R7", 30, 64'h3030, mk(1, 0, 0, 16'h30));

        repeat (70) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule